// File: doc/BRIEF.md
# Chunk-Redundant Cache Line Combiner

This block is the read and write datapath of a cache data array that keeps working when some of its storage cells fail at low supply voltage. Physical lines are grouped so that the data lines of a group never have a faulty chunk in the same position. One line per group is given up as a spare. A lookup table gives, for every line, whether it is a usable data line and which spare line serves it. A second table gives a per-chunk fault vector. A data line and its spare always sit in opposite banks, so both are read in the same cycle. A per-chunk multiplexer layer builds the returned line from the spare's chunk wherever the data chunk is flagged faulty. Writes are split the same way: healthy chunks go to the data line and flagged chunks go to the spare.

A mode input selects between the low-voltage mode, where the mechanism is active, and the nominal-voltage mode, where both tables are ignored and every physical line is an ordinary line. The tables are loaded through a configuration port, as a self-test would fill them. Requests use a valid/ready handshake and produce a response one cycle after acceptance. A fault-injection input forces chosen chunks of one physical line to read as all ones, which models stuck-at cells.

Top module: `ccomb_top`

## Requirements
- R1: After reset `resp_valid` is 0, `req_ready` is 1, and every table entry reads as disabled with no faulty chunks, so any low-voltage access returns an error.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. Exactly one response with `resp_valid`=1 follows in the next cycle. No response appears in a cycle that follows no acceptance.
- R3: `req_ready` is 0 in every cycle in which `cfg_we` is 1. A table entry written in that cycle governs accesses from the next cycle on.
- R4: With `lp_mode`=0 every physical line is addressable, reads return the stored line unchanged (including injected stuck bits), and `resp_err` is never set.
- R5: A low-voltage write to a data line stores its non-flagged chunks in that line and its flagged chunks at the same chunk positions of its spare line. The spare is in the opposite bank, at the index from the table. Both are written in the same cycle and all other chunks are left unchanged.
- R6: A low-voltage read of a data line returns the spare's chunk at each flagged position and the data line's own chunk elsewhere. Stuck bits in flagged chunks therefore never reach `resp_rdata`.
- R7: A low-voltage access to a line whose kind is not data (kind code 0 = disabled, 2 = spare) returns `resp_err`=1 with `resp_rdata`=0 and modifies no line.
- R8: Two data lines that share a spare and have disjoint fault vectors keep independent contents across writes to either.
- R9: Address bit ADDR_W-1 selects the bank and the lower bits select the index within it. Chunk c occupies bits [c*CHUNK_W +: CHUNK_W] of a line, and fault bit c flags chunk c. Kind code 1 marks a data line.
- R10: The response to a write carries `resp_rdata`=0, and it carries `resp_err`=0 unless R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode | input | 1 | 1 = low-voltage mode (redundancy active), 0 = bypass |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Physical line address: bank bit, then index |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response valid, one cycle after acceptance |
| resp_err | output | 1 | Access hit a non-data line in low-voltage mode |
| resp_rdata | output | 32 | Read data, zero on writes and errors |
| cfg_we | input | 1 | Write one table entry |
| cfg_addr | input | 4 | Line whose entry is written |
| cfg_kind | input | 2 | Line kind: 0 disabled, 1 data, 2 spare |
| cfg_spare_idx | input | 3 | Index of the spare line in the opposite bank |
| cfg_fault | input | 4 | Per-chunk fault flags for the line |
| inj_en | input | 1 | Enable stuck-at-one injection |
| inj_addr | input | 4 | Physical line that carries stuck chunks |
| inj_mask | input | 4 | Chunks of that line forced to all ones on read |

## Verification
The assertions assume that the tables describe a valid grouping. Every data line's spare is marked as a spare, and no two data lines that share a spare have a faulty chunk in the same position. They also assume that injected stuck bits sit only in chunks the fault table flags. The bench programs two data lines with disjoint fault vectors onto one spare and a third data line onto a spare in the other direction. It injects stuck-at-one bits only into flagged chunks of a configured line. It holds `req_valid` low while it loads the tables, so the stimulus never relies on a request being accepted during a table write.

// File: rtl/ccomb_pkg.sv
package ccomb_pkg;

    parameter int CHUNK_W    = 8;
    parameter int NCHUNK     = 4;
    parameter int BANK_LINES = 8;

    localparam int LINE_W = CHUNK_W * NCHUNK;
    localparam int IDX_W  = $clog2(BANK_LINES);
    localparam int ADDR_W = IDX_W + 1;
    localparam int NLINES = 2 * BANK_LINES;

    typedef enum logic [1:0] {
        LK_OFF   = 2'd0,
        LK_DATA  = 2'd1,
        LK_SPARE = 2'd2
    } line_kind_e;

    typedef struct packed {
        line_kind_e           kind;
        logic [IDX_W-1:0]     spare_idx;
        logic [NCHUNK-1:0]    fault;
    } map_ent_t;

    typedef struct packed {
        logic                 bank;
        logic [IDX_W-1:0]     idx;
    } line_addr_t;

    function automatic logic [LINE_W-1:0] chunk_to_bits(input logic [NCHUNK-1:0] m);
        logic [LINE_W-1:0] r;
        for (int c = 0; c < NCHUNK; c++) begin
            r[c*CHUNK_W +: CHUNK_W] = {CHUNK_W{m[c]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/ccomb_bank.sv
module ccomb_bank
    import ccomb_pkg::*;
#(
    parameter int BANK_ID = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 we,
    input  logic [NCHUNK-1:0]    wmask,
    input  logic [LINE_W-1:0]    wdata,
    output logic [LINE_W-1:0]    rdata,
    input  logic                 inj_en,
    input  logic [ADDR_W-1:0]    inj_addr,
    input  logic [NCHUNK-1:0]    inj_mask
);

    localparam logic BSEL = BANK_ID[0];

    logic [LINE_W-1:0] mem_q [BANK_LINES];
    logic [LINE_W-1:0] wbits;
    logic              inj_hit;

    assign wbits   = chunk_to_bits(wmask);
    assign inj_hit = inj_en && (inj_addr == {BSEL, idx});

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BANK_LINES; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[idx] <= (mem_q[idx] & ~wbits) | (wdata & wbits);
        end
    end

    // stuck-at-one cells override stored bits on the read path
    assign rdata = mem_q[idx] | (inj_hit ? chunk_to_bits(inj_mask) : '0);

endmodule

// File: rtl/ccomb_maps.sv
module ccomb_maps
    import ccomb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  map_ent_t             cfg_ent,
    input  logic                 look_en,
    input  logic [ADDR_W-1:0]    look_addr,
    output map_ent_t             look_ent
);

    map_ent_t ent_q [NLINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) begin
                ent_q[i] <= '{kind: LK_OFF, spare_idx: '0, fault: '0};
            end
        end else if (cfg_we) begin
            ent_q[cfg_addr] <= cfg_ent;
        end
    end

    // in bypass mode the tables are not consulted
    assign look_ent = look_en ? ent_q[look_addr] : '0;

endmodule

// File: rtl/ccomb_mux.sv
module ccomb_mux
    import ccomb_pkg::*;
(
    input  logic [NCHUNK-1:0]    fault,
    input  logic [LINE_W-1:0]    own_line,
    input  logic [LINE_W-1:0]    spare_line,
    output logic [LINE_W-1:0]    merged,
    output logic [NCHUNK-1:0]    own_wmask,
    output logic [NCHUNK-1:0]    spare_wmask
);

    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        assign merged[c*CHUNK_W +: CHUNK_W] = fault[c] ? spare_line[c*CHUNK_W +: CHUNK_W]
                                                       : own_line[c*CHUNK_W +: CHUNK_W];
        assign own_wmask[c]   = ~fault[c];
        assign spare_wmask[c] =  fault[c];
    end

endmodule

// File: rtl/ccomb_top.sv
module ccomb_top
    import ccomb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lp_mode,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LINE_W-1:0]    req_wdata,
    output logic                 resp_valid,
    output logic                 resp_err,
    output logic [LINE_W-1:0]    resp_rdata,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [1:0]           cfg_kind,
    input  logic [IDX_W-1:0]     cfg_spare_idx,
    input  logic [NCHUNK-1:0]    cfg_fault,
    input  logic                 inj_en,
    input  logic [ADDR_W-1:0]    inj_addr,
    input  logic [NCHUNK-1:0]    inj_mask
);

    line_addr_t          ra;
    map_ent_t            cfg_ent;
    map_ent_t            ent;
    logic                fire;
    logic                bad_line;
    logic [NCHUNK-1:0]   fault_eff;
    logic [LINE_W-1:0]   rd_line [2];
    logic [LINE_W-1:0]   own_line;
    logic [LINE_W-1:0]   spare_line;
    logic [LINE_W-1:0]   merged;
    logic [NCHUNK-1:0]   own_wmask;
    logic [NCHUNK-1:0]   spare_wmask;
    logic                bank_we;

    assign ra        = line_addr_t'(req_addr);
    assign req_ready = ~cfg_we;
    assign fire      = req_valid & req_ready;

    assign cfg_ent = '{kind: line_kind_e'(cfg_kind), spare_idx: cfg_spare_idx, fault: cfg_fault};

    ccomb_maps u_maps (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_ent   (cfg_ent),
        .look_en   (lp_mode),
        .look_addr (req_addr),
        .look_ent  (ent)
    );

    assign bad_line  = lp_mode && (ent.kind != LK_DATA);
    assign fault_eff = lp_mode ? ent.fault : '0;
    assign bank_we   = fire & req_we & ~bad_line;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic               is_own;
        logic [IDX_W-1:0]   b_idx;
        logic [NCHUNK-1:0]  b_mask;

        assign is_own = (ra.bank == b[0]);
        assign b_idx  = is_own ? ra.idx : ent.spare_idx;
        assign b_mask = is_own ? own_wmask : spare_wmask;

        ccomb_bank #(.BANK_ID(b)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .idx      (b_idx),
            .we       (bank_we),
            .wmask    (b_mask),
            .wdata    (req_wdata),
            .rdata    (rd_line[b]),
            .inj_en   (inj_en),
            .inj_addr (inj_addr),
            .inj_mask (inj_mask)
        );
    end

    assign own_line   = rd_line[ra.bank];
    assign spare_line = rd_line[~ra.bank];

    ccomb_mux u_mux (
        .fault       (fault_eff),
        .own_line    (own_line),
        .spare_line  (spare_line),
        .merged      (merged),
        .own_wmask   (own_wmask),
        .spare_wmask (spare_wmask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= fire;
            resp_err   <= fire & bad_line;
            resp_rdata <= (fire & ~req_we & ~bad_line) ? merged : '0;
        end
    end

endmodule

// File: rtl/ccomb_chk.sv
module ccomb_chk
    import ccomb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lp_mode,
    input  logic                 req_valid,
    input  logic                 req_ready,
    input  logic                 req_we,
    input  logic                 resp_valid,
    input  logic                 resp_err,
    input  logic [LINE_W-1:0]    resp_rdata,
    input  logic                 cfg_we
);

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid);

    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !resp_valid);

    p_ready_low_cfg_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> !req_ready);

    p_bypass_no_err_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !lp_mode) |=> !resp_err);

    p_err_zero_data_r7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |-> (resp_rdata == '0));

    p_write_resp_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_we) |=> (resp_rdata == '0));

    p_err_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> resp_valid);

endmodule

bind ccomb_top ccomb_chk u_chk (.*);

// File: tb/tb_ccomb_top.sv
module tb_ccomb_top;
    import ccomb_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 lp_mode;
    logic                 req_valid;
    logic                 req_ready;
    logic                 req_we;
    logic [ADDR_W-1:0]    req_addr;
    logic [LINE_W-1:0]    req_wdata;
    logic                 resp_valid;
    logic                 resp_err;
    logic [LINE_W-1:0]    resp_rdata;
    logic                 cfg_we;
    logic [ADDR_W-1:0]    cfg_addr;
    logic [1:0]           cfg_kind;
    logic [IDX_W-1:0]     cfg_spare_idx;
    logic [NCHUNK-1:0]    cfg_fault;
    logic                 inj_en;
    logic [ADDR_W-1:0]    inj_addr;
    logic [NCHUNK-1:0]    inj_mask;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ccomb_top dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one request, response sampled at the negedge after the accepting edge
    task automatic access(input logic lp, input logic we, input logic [ADDR_W-1:0] a,
                          input logic [LINE_W-1:0] wd, output logic err,
                          output logic [LINE_W-1:0] rd, output logic vld);
        @(negedge clk);
        lp_mode = lp; req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        vld = resp_valid; err = resp_err; rd = resp_rdata;
    endtask

    task automatic cfg(input logic [ADDR_W-1:0] a, input logic [1:0] k,
                       input logic [IDX_W-1:0] s, input logic [NCHUNK-1:0] f);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_kind = k; cfg_spare_idx = s; cfg_fault = f;
        #1 check("R3 ready low during table write", 64'(req_ready), 64'd0);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        logic e, v; logic [LINE_W-1:0] d;
        check("R1 resp_valid after reset", 64'(resp_valid), 64'd0);
        check("R1 req_ready after reset", 64'(req_ready), 64'd1);
        access(1'b1, 1'b0, 4'h3, '0, e, d, v);
        check("R1 cleared table gives error", 64'(e), 64'd1);
        check("R7 error read data zero", 64'(d), 64'd0);
    endtask

    task automatic t_bypass;
        logic e, v; logic [LINE_W-1:0] d;
        access(1'b0, 1'b1, 4'h1, 32'hCAFE0001, e, d, v);
        check("R10 write resp data zero", 64'(d), 64'd0);
        check("R10 write resp no error", 64'(e), 64'd0);
        check("R2 write response valid", 64'(v), 64'd1);
        access(1'b0, 1'b1, 4'hA, 32'h0BADF00D, e, d, v);
        access(1'b0, 1'b0, 4'h1, '0, e, d, v);
        check("R4 bypass read bank0", 64'(d), 64'hCAFE0001);
        check("R4 bypass no error", 64'(e), 64'd0);
        access(1'b0, 1'b0, 4'hA, '0, e, d, v);
        check("R4 bypass read bank1", 64'(d), 64'h0BADF00D);
        @(negedge clk);
        check("R2 no response when idle", 64'(resp_valid), 64'd0);
    endtask

    task automatic t_lowvolt;
        logic e, v; logic [LINE_W-1:0] d;
        // R9: line 2 = bank0 idx2, spare idx5 -> line 13 (bank1); kind 1 data, 2 spare
        cfg(4'h2,  2'd1, 3'd5, 4'b0101);
        cfg(4'h4,  2'd1, 3'd5, 4'b1000);
        cfg(4'hD,  2'd2, 3'd0, 4'b0000);
        cfg(4'h9,  2'd1, 3'd3, 4'b0010);
        cfg(4'h3,  2'd2, 3'd0, 4'b0000);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = 4'h2; inj_mask = 4'b0101;
        access(1'b1, 1'b1, 4'h2, 32'h11223344, e, d, v);
        check("R10 lp write no error", 64'(e), 64'd0);
        access(1'b1, 1'b1, 4'h4, 32'hAABBCCDD, e, d, v);
        access(1'b1, 1'b0, 4'h2, '0, e, d, v);
        check("R6 merged read masks stuck chunks", 64'(d), 64'h11223344);
        access(1'b1, 1'b0, 4'h4, '0, e, d, v);
        check("R8 sharer keeps own data", 64'(d), 64'hAABBCCDD);
        access(1'b1, 1'b0, 4'hD, '0, e, d, v);
        check("R7 spare line read errors", 64'(e), 64'd1);
        access(1'b1, 1'b1, 4'hD, 32'hFFFFFFFF, e, d, v);
        check("R7 spare line write errors", 64'(e), 64'd1);
        access(1'b1, 1'b1, 4'h6, 32'hFFFFFFFF, e, d, v);
        check("R7 disabled line errors", 64'(e), 64'd1);
        access(1'b0, 1'b0, 4'hD, '0, e, d, v);
        check("R5 spare holds flagged chunks", 64'(d), 64'hAA220044);
        access(1'b0, 1'b0, 4'h6, '0, e, d, v);
        check("R7 disabled line unchanged", 64'(d), 64'h00000000);
        access(1'b0, 1'b0, 4'h2, '0, e, d, v);
        check("R4 bypass shows stuck bits", 64'(d), 64'h11FF33FF);
        access(1'b0, 1'b0, 4'h4, '0, e, d, v);
        check("R5 data line skips flagged chunk", 64'(d), 64'h00BBCCDD);
        access(1'b1, 1'b1, 4'h9, 32'hDEADBEEF, e, d, v);
        access(1'b0, 1'b0, 4'h3, '0, e, d, v);
        check("R9 spare in bank0 for bank1 line", 64'(d), 64'h0000BE00);
        access(1'b1, 1'b0, 4'h9, '0, e, d, v);
        check("R6 merged read bank1 line", 64'(d), 64'hDEADBEEF);
        access(1'b1, 1'b0, 4'h2, '0, e, d, v);
        check("R8 first sharer intact", 64'(d), 64'h11223344);
    endtask

    initial begin
        rst = 1'b1; lp_mode = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0;
        req_wdata = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_kind = '0; cfg_spare_idx = '0;
        cfg_fault = '0; inj_en = 1'b0; inj_addr = '0; inj_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_lowvolt();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule